// File: doc/BRIEF.md
# Task Switch State Sequencer

This block carries out a hardware task switch as a fixed series of word and doubleword accesses on one memory port. A switch request arrives with a kind (JMP, CALL, interrupt or IRET), the selector, base, limit and width of the incoming task state segment, the base and width of the outgoing one, and the live register state of the outgoing task. The sequencer first vets the request, then reads the complete context of the incoming task, stores the outgoing context into its own segment, writes the back link where the switch kind calls for it, and finally presents the new context, the new task register contents and the I/O permission window.

The busy bit of each segment lives outside the block, so the sequencer reports the busy updates as strobes. Segment descriptor validation, loading of the local descriptor table and page-table checks also belong to other logic; the block only raises a strobe telling that logic to proceed with the selectors it has just delivered. The outgoing register state is sampled directly from the core's register file, which the core keeps frozen for the whole switch.

Top module: `task_switch_seq`

## Requirements
- R1: A request whose incoming limit is below 0x67 (32-bit segment) or below 0x2B (16-bit segment) ends with faultCode 1 (invalid segment), makes no memory access, raises none of setTs, segLoad, setNewBusy, clrOldBusy, and leaves the task register outputs unchanged.
- R2: For a 32-bit incoming segment the block reads, relative to newBase, the instruction pointer at 32 and flags at 36 (doublewords), general register i at 40+4i (doubleword, i=0..7), selector i at 72+4i (word, i=0..5), the local table selector at 96, the trap bit as bit 0 of the word at 100 and the I/O base word at 102; the table root doubleword at 28 is read only when pagingOn is 1 and is delivered on newCr3 (zero otherwise).
- R3: For a 16-bit incoming segment the block reads words: instruction pointer at 14, flags at 16, general register i at 18+2i, selector i at 34+2i for i=0..3 and the local table selector at 42; all values are zero-extended, selectors 4 and 5, newTrap, newCr3 and the I/O window are zero.
- R4: Every read of the incoming context is complete before the first write of the switch.
- R5: The outgoing instruction pointer, flags, eight general registers and selectors (six for 32-bit, four for 16-bit) are written relative to curBase at the same offsets and widths the layout of the outgoing width uses; for IRET the stored flags have bit 14 (nested task) cleared.
- R6: For CALL (kind 1) and interrupt (kind 2) the word curSel is written at newBase+0 after the save and newFlags carries bit 14 set; for JMP (kind 0) and IRET (kind 3) offset 0 is not written and newFlags is the value read.
- R7: A completed switch pulses setNewBusy for JMP, CALL and interrupt and clrOldBusy for JMP and IRET; an IRET with newBusy low ends with faultCode 3 and no memory access, while newBusy is ignored for the other kinds.
- R8: A completed switch pulses done together with setTs and segLoad, pulses cr3Load when the incoming segment is 32-bit and pagingOn is 1, and loads trSel, trBase, trLimit and trIs32 from the incoming request; done is a single-cycle pulse.
- R9: For a 32-bit incoming segment with an I/O base b where b is nonzero and below the incoming limit L, ioLimit is the low 16 bits of L-b and ioAddr is newBase+b; otherwise both are zero.
- R10: If the new instruction pointer is greater than csLimit the switch still completes but faultCode is 2; an instruction pointer equal to csLimit gives faultCode 0.
- R11: Each access holds memReq, memAddr, memWe and memWide (1 = 32 bits, 0 = 16 bits) stable until memAck; a switch makes 20 reads (19 without paging) for 32-bit or 15 for 16-bit, 16 or 14 writes for the outgoing width, plus one link write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Starts a switch when the block is idle |
| kind | input | 2 | Switch kind: 0 JMP, 1 CALL, 2 interrupt, 3 IRET |
| newSel | input | 16 | Incoming task selector |
| newBase | input | 32 | Incoming segment base |
| newLimit | input | 32 | Incoming segment limit |
| newIs32 | input | 1 | Incoming segment is the 32-bit layout |
| newBusy | input | 1 | Busy bit of the incoming task |
| curSel | input | 16 | Current task selector |
| curBase | input | 32 | Current segment base |
| curIs32 | input | 1 | Current segment is the 32-bit layout |
| pagingOn | input | 1 | Paging enabled |
| csLimit | input | 32 | Limit of the incoming code segment |
| curIp | input | 32 | Outgoing instruction pointer |
| curFlags | input | 32 | Outgoing flags |
| curGpr | input | 256 | Outgoing general registers, register i at bits 32i+31:32i |
| curSeg | input | 96 | Outgoing selectors, selector i at bits 16i+15:16i |
| memReq | output | 1 | Access request |
| memWe | output | 1 | Access is a write |
| memWide | output | 1 | Access width, 1 = 32 bits |
| memAddr | output | 32 | Byte address |
| memWdata | output | 32 | Write data |
| memRdata | input | 32 | Read data, valid with memAck |
| memAck | input | 1 | Access complete |
| done | output | 1 | Switch finished (one cycle) |
| faultCode | output | 2 | 0 none, 1 invalid segment, 2 protection, 3 not busy |
| setTs | output | 1 | Set the task-switched control bit |
| clrOldBusy | output | 1 | Clear busy bit of outgoing task |
| setNewBusy | output | 1 | Set busy bit of incoming task |
| segLoad | output | 1 | Downstream may validate selectors and local table |
| cr3Load | output | 1 | Load newCr3 into the table root |
| newIp | output | 32 | New instruction pointer |
| newFlags | output | 32 | New flags |
| newGpr | output | 256 | New general registers |
| newSeg | output | 96 | New selectors |
| newLdt | output | 16 | New local table selector |
| newTrap | output | 1 | New trap bit |
| newCr3 | output | 32 | New table root |
| ioLimit | output | 16 | I/O window length |
| ioAddr | output | 32 | I/O window address |
| trSel | output | 16 | Task register selector |
| trBase | output | 32 | Task register base |
| trLimit | output | 32 | Task register limit |
| trIs32 | output | 1 | Task register width |

## Verification
The bench sweeps every kind against both incoming widths, both outgoing widths and paging on and off, then targets the limit one below and exactly at each minimum, an IRET into a task that is not busy, and an instruction pointer equal to and one above the code limit. A design that let a short segment through, or vetted busy after starting traffic, would show memory accesses or strobes on a faulted request; an off-by-one offset or a wrong width tag corrupts a captured register or the upper half of a stored doubleword. I/O bases of zero, inside the limit and beyond it expose a window that is opened when it should stay shut, and a missing paging skip shows as an extra read and a nonzero table root.

// File: rtl/tsw_pkg.sv
package tsw_pkg;
  localparam int GPR_N   = 8;
  localparam int SEG32_N = 6;
  localparam int SEG16_N = 4;
  localparam int NT_POS  = 14;
  localparam int STEP_W  = 5;
  localparam int GPR_W   = 32;
  localparam int SEL_W   = 16;
  localparam logic [31:0] MIN_LIM32 = 32'h67;
  localparam logic [31:0] MIN_LIM16 = 32'h2B;
  localparam logic [31:0] NT_MASK   = 32'(1) << NT_POS;

  typedef enum logic [1:0] {KIND_JMP = 2'd0, KIND_CALL = 2'd1, KIND_INTR = 2'd2, KIND_IRET = 2'd3} kind_e;
  typedef enum logic [1:0] {FLT_NONE = 2'd0, FLT_TSS = 2'd1, FLT_GP = 2'd2, FLT_BUSY = 2'd3} fault_e;
  typedef enum logic [1:0] {PH_READ, PH_SAVE, PH_LINK} phase_e;

  typedef struct packed {
    logic              latch;
    logic              capture;
    logic              finish;
    phase_e            phase;
    logic [STEP_W-1:0] step;
  } ctl_s;
endpackage

// File: rtl/tsw_ctrl.sv
module tsw_ctrl
  import tsw_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   start,
  input  kind_e  kindQ,
  input  logic   new32,
  input  logic   old32,
  input  logic   paging,
  input  logic   limitOk,
  input  logic   busyOk,
  input  logic   ipOver,
  input  logic   memAck,
  output ctl_s   ctl,
  output logic   memReq,
  output logic   done,
  output fault_e faultCode,
  output logic   setTs,
  output logic   clrOldBusy,
  output logic   setNewBusy,
  output logic   segLoad,
  output logic   cr3Load
);
  typedef enum logic [2:0] {S_IDLE, S_CHECK, S_READ, S_SAVE, S_LINK, S_DONE} st_e;
  st_e st;
  logic [STEP_W-1:0] step, lastRd, lastWr;
  fault_e flt;
  logic linkNeeded, okDone;

  always_comb begin
    lastRd     = new32 ? STEP_W'(19) : STEP_W'(14);
    lastWr     = old32 ? STEP_W'(15) : STEP_W'(13);
    linkNeeded = (kindQ == KIND_CALL) || (kindQ == KIND_INTR);
    ctl.latch   = (st == S_IDLE) && start;
    ctl.capture = (st == S_READ) && memAck;
    ctl.finish  = ((st == S_SAVE) && memAck && (step == lastWr) && !linkNeeded)
                || ((st == S_LINK) && memAck);
    ctl.phase   = (st == S_SAVE) ? PH_SAVE : (st == S_LINK) ? PH_LINK : PH_READ;
    ctl.step    = step;
    memReq      = (st == S_READ) || (st == S_SAVE) || (st == S_LINK);
    done        = (st == S_DONE);
    okDone      = done && (flt == FLT_NONE);
    faultCode   = (okDone && ipOver) ? FLT_GP : (done ? flt : FLT_NONE);
    setTs       = okDone;
    segLoad     = okDone;
    clrOldBusy  = okDone && ((kindQ == KIND_JMP) || (kindQ == KIND_IRET));
    setNewBusy  = okDone && (kindQ != KIND_IRET);
    cr3Load     = okDone && new32 && paging;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st   <= S_IDLE;
      step <= '0;
      flt  <= FLT_NONE;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          st  <= S_CHECK;
          flt <= FLT_NONE;
        end
        S_CHECK: begin
          if (!limitOk) begin
            flt <= FLT_TSS;
            st  <= S_DONE;
          end else if (!busyOk) begin
            flt <= FLT_BUSY;
            st  <= S_DONE;
          end else begin
            st   <= S_READ;
            step <= (new32 && !paging) ? STEP_W'(1) : '0;
          end
        end
        S_READ: if (memAck) begin
          if (step == lastRd) begin
            st   <= S_SAVE;
            step <= '0;
          end else step <= step + 1'b1;
        end
        S_SAVE: if (memAck) begin
          if (step == lastWr) st <= linkNeeded ? S_LINK : S_DONE;
          else step <= step + 1'b1;
        end
        S_LINK: if (memAck) st <= S_DONE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tsw_dp.sv
module tsw_dp
  import tsw_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  ctl_s                   ctl,
  input  logic [1:0]             kind,
  input  logic [SEL_W-1:0]       newSel,
  input  logic [31:0]            newBase,
  input  logic [31:0]            newLimit,
  input  logic                   newIs32,
  input  logic                   newBusy,
  input  logic [SEL_W-1:0]       curSel,
  input  logic [31:0]            curBase,
  input  logic                   curIs32,
  input  logic                   pagingOn,
  input  logic [31:0]            csLimit,
  input  logic [31:0]            curIp,
  input  logic [31:0]            curFlags,
  input  logic [GPR_N*GPR_W-1:0] curGpr,
  input  logic [SEG32_N*SEL_W-1:0] curSeg,
  input  logic [31:0]            memRdata,
  output kind_e                  kindQ,
  output logic                   new32Q,
  output logic                   old32Q,
  output logic                   pagingQ,
  output logic                   limitOk,
  output logic                   busyOk,
  output logic                   ipOver,
  output logic                   memWe,
  output logic                   memWide,
  output logic [31:0]            memAddr,
  output logic [31:0]            memWdata,
  output logic [31:0]            newIp,
  output logic [31:0]            newFlags,
  output logic [GPR_N*GPR_W-1:0] newGpr,
  output logic [SEG32_N*SEL_W-1:0] newSeg,
  output logic [SEL_W-1:0]       newLdt,
  output logic                   newTrap,
  output logic [31:0]            newCr3,
  output logic [15:0]            ioLimit,
  output logic [31:0]            ioAddr,
  output logic [SEL_W-1:0]       trSel,
  output logic [31:0]            trBase,
  output logic [31:0]            trLimit,
  output logic                   trIs32
);
  logic [GPR_W-1:0] gprIn [GPR_N];
  logic [SEL_W-1:0] segIn [SEG32_N];
  logic [GPR_W-1:0] gprQ  [GPR_N];
  logic [SEL_W-1:0] segQ  [SEG32_N];
  logic [SEL_W-1:0] newSelQ, curSelQ, iobQ;
  logic [31:0] newBaseQ, newLimitQ, curBaseQ, csLimitQ;
  logic newBusyQ;
  logic [31:0] off, base, wval, capRd;
  int s, capK, nSeg;

  for (genvar g = 0; g < GPR_N; g++) begin : gGpr
    assign gprIn[g] = curGpr[g*GPR_W +: GPR_W];
    assign newGpr[g*GPR_W +: GPR_W] = gprQ[g];
  end
  for (genvar g = 0; g < SEG32_N; g++) begin : gSeg
    assign segIn[g] = curSeg[g*SEL_W +: SEL_W];
    assign newSeg[g*SEL_W +: SEL_W] = segQ[g];
  end

  assign limitOk = new32Q ? (newLimitQ >= MIN_LIM32) : (newLimitQ >= MIN_LIM16);
  assign busyOk  = (kindQ != KIND_IRET) || newBusyQ;
  assign ipOver  = newIp > csLimitQ;

  always_comb begin
    s    = int'(ctl.step);
    nSeg = new32Q ? SEG32_N : SEG16_N;
    case (ctl.phase)
      PH_READ: begin
        base    = newBaseQ;
        off     = new32Q ? ((s == 19) ? 32'd102 : 32'(28 + 4*s)) : 32'(14 + 2*s);
        memWide = new32Q && (s <= 10);
      end
      PH_SAVE: begin
        base    = curBaseQ;
        off     = old32Q ? 32'(32 + 4*s) : 32'(14 + 2*s);
        memWide = old32Q && (s <= 9);
      end
      default: begin
        base    = newBaseQ;
        off     = '0;
        memWide = 1'b0;
      end
    endcase
    memAddr = base + off;
    memWe   = (ctl.phase != PH_READ);
    wval    = '0;
    if (ctl.phase == PH_LINK) wval = {16'b0, curSelQ};
    else if (s == 0) wval = curIp;
    else if (s == 1) wval = curFlags & ~((kindQ == KIND_IRET) ? NT_MASK : 32'b0);
    else if (s <= 9) wval = gprIn[3'(s-2)];
    else if (s - 10 < SEG32_N) wval = {16'b0, segIn[3'(s-10)]};
    memWdata = memWide ? wval : {16'b0, wval[15:0]};
    capRd    = memWide ? memRdata : {16'b0, memRdata[15:0]};
    capK     = new32Q ? s - 1 : s;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      kindQ <= KIND_JMP; new32Q <= 1'b0; old32Q <= 1'b0; pagingQ <= 1'b0; newBusyQ <= 1'b0;
      newSelQ <= '0; curSelQ <= '0; newBaseQ <= '0; newLimitQ <= '0; curBaseQ <= '0; csLimitQ <= '0;
      newIp <= '0; newFlags <= '0; newLdt <= '0; newTrap <= 1'b0; newCr3 <= '0; iobQ <= '0;
      for (int i = 0; i < GPR_N; i++) gprQ[i] <= '0;
      for (int i = 0; i < SEG32_N; i++) segQ[i] <= '0;
      ioLimit <= '0; ioAddr <= '0; trSel <= '0; trBase <= '0; trLimit <= '0; trIs32 <= 1'b0;
    end else begin
      if (ctl.latch) begin
        kindQ <= kind_e'(kind); new32Q <= newIs32; old32Q <= curIs32; pagingQ <= pagingOn;
        newBusyQ <= newBusy; newSelQ <= newSel; curSelQ <= curSel; newBaseQ <= newBase;
        newLimitQ <= newLimit; curBaseQ <= curBase; csLimitQ <= csLimit;
        newIp <= '0; newFlags <= '0; newLdt <= '0; newTrap <= 1'b0; newCr3 <= '0; iobQ <= '0;
        for (int i = 0; i < GPR_N; i++) gprQ[i] <= '0;
        for (int i = 0; i < SEG32_N; i++) segQ[i] <= '0;
      end
      if (ctl.capture) begin
        if (new32Q && s == 0) newCr3 <= capRd;
        else if (capK == 0) newIp <= capRd;
        else if (capK == 1)
          newFlags <= capRd | (((kindQ == KIND_CALL) || (kindQ == KIND_INTR)) ? NT_MASK : 32'b0);
        else if (capK <= 9) gprQ[3'(capK-2)] <= capRd;
        else if (capK < 10 + nSeg) segQ[3'(capK-10)] <= capRd[15:0];
        else if (capK == 10 + nSeg) newLdt <= capRd[15:0];
        else if (capK == 17) newTrap <= capRd[0];
        else iobQ <= capRd[15:0];
      end
      if (ctl.finish) begin
        trSel <= newSelQ; trBase <= newBaseQ; trLimit <= newLimitQ; trIs32 <= new32Q;
        if (new32Q && iobQ != '0 && {16'b0, iobQ} < newLimitQ) begin
          ioLimit <= 16'(newLimitQ - {16'b0, iobQ});
          ioAddr  <= newBaseQ + {16'b0, iobQ};
        end else begin
          ioLimit <= '0;
          ioAddr  <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/task_switch_seq.sv
module task_switch_seq
  import tsw_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     start,
  input  logic [1:0]               kind,
  input  logic [SEL_W-1:0]         newSel,
  input  logic [31:0]              newBase,
  input  logic [31:0]              newLimit,
  input  logic                     newIs32,
  input  logic                     newBusy,
  input  logic [SEL_W-1:0]         curSel,
  input  logic [31:0]              curBase,
  input  logic                     curIs32,
  input  logic                     pagingOn,
  input  logic [31:0]              csLimit,
  input  logic [31:0]              curIp,
  input  logic [31:0]              curFlags,
  input  logic [GPR_N*GPR_W-1:0]   curGpr,
  input  logic [SEG32_N*SEL_W-1:0] curSeg,
  output logic                     memReq,
  output logic                     memWe,
  output logic                     memWide,
  output logic [31:0]              memAddr,
  output logic [31:0]              memWdata,
  input  logic [31:0]              memRdata,
  input  logic                     memAck,
  output logic                     done,
  output logic [1:0]               faultCode,
  output logic                     setTs,
  output logic                     clrOldBusy,
  output logic                     setNewBusy,
  output logic                     segLoad,
  output logic                     cr3Load,
  output logic [31:0]              newIp,
  output logic [31:0]              newFlags,
  output logic [GPR_N*GPR_W-1:0]   newGpr,
  output logic [SEG32_N*SEL_W-1:0] newSeg,
  output logic [SEL_W-1:0]         newLdt,
  output logic                     newTrap,
  output logic [31:0]              newCr3,
  output logic [15:0]              ioLimit,
  output logic [31:0]              ioAddr,
  output logic [SEL_W-1:0]         trSel,
  output logic [31:0]              trBase,
  output logic [31:0]              trLimit,
  output logic                     trIs32
);
  ctl_s   ctl;
  kind_e  kindQ;
  fault_e fltE;
  logic new32Q, old32Q, pagingQ, limitOk, busyOk, ipOver;

  assign faultCode = fltE;

  tsw_ctrl u_ctrl (
    .clk, .rstN, .start, .kindQ, .new32(new32Q), .old32(old32Q), .paging(pagingQ),
    .limitOk, .busyOk, .ipOver, .memAck, .ctl, .memReq, .done, .faultCode(fltE),
    .setTs, .clrOldBusy, .setNewBusy, .segLoad, .cr3Load
  );

  tsw_dp u_dp (
    .clk, .rstN, .ctl, .kind, .newSel, .newBase, .newLimit, .newIs32, .newBusy,
    .curSel, .curBase, .curIs32, .pagingOn, .csLimit, .curIp, .curFlags, .curGpr, .curSeg,
    .memRdata, .kindQ, .new32Q, .old32Q, .pagingQ, .limitOk, .busyOk, .ipOver,
    .memWe, .memWide, .memAddr, .memWdata, .newIp, .newFlags, .newGpr, .newSeg,
    .newLdt, .newTrap, .newCr3, .ioLimit, .ioAddr, .trSel, .trBase, .trLimit, .trIs32
  );
endmodule

// File: rtl/tsw_chk.sv
module tsw_chk (
  input logic        clk,
  input logic        rstN,
  input logic        memReq,
  input logic        memWe,
  input logic        memAck,
  input logic [31:0] memAddr,
  input logic        done,
  input logic [1:0]  faultCode,
  input logic        setTs,
  input logic        setNewBusy,
  input logic        clrOldBusy,
  input logic        segLoad,
  input logic        trIs32,
  input logic [15:0] ioLimit
);
  logic wrSeen;
  always_ff @(posedge clk) begin
    if (!rstN) wrSeen <= 1'b0;
    else if (done) wrSeen <= 1'b0;
    else if (memReq && memWe && memAck) wrSeen <= 1'b1;
  end

  AST_READS_BEFORE_WRITES: assert property (@(posedge clk) disable iff (!rstN)
    (wrSeen && memReq) |-> memWe); // R4
  AST_PORT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr) && $stable(memWe))); // R11
  AST_EARLY_FAULT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (done && (faultCode == 2'd1 || faultCode == 2'd3)) |-> !(setTs || segLoad || setNewBusy || clrOldBusy)); // R1
  AST_FINISH_STROBES: assert property (@(posedge clk) disable iff (!rstN)
    (done && faultCode != 2'd1 && faultCode != 2'd3) |-> (setTs && segLoad)); // R8
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R8
  AST_BUSY_ACTION: assert property (@(posedge clk) disable iff (!rstN)
    setTs |-> (setNewBusy || clrOldBusy)); // R7
  AST_IO_NARROW_SHUT: assert property (@(posedge clk) disable iff (!rstN)
    (setTs && !trIs32) |-> (ioLimit == 16'd0)); // R9
endmodule

bind task_switch_seq tsw_chk u_chk (.*);

// File: tb/sim_task_switch_seq.sv
module sim_task_switch_seq;
  logic clk = 1'b0, rstN = 1'b0, start = 1'b0;
  logic [1:0] kind = '0;
  logic [15:0] newSel = '0, curSel = '0;
  logic [31:0] newBase = '0, newLimit = '0, curBase = '0, csLimit = '0, curIp = '0, curFlags = '0;
  logic newIs32 = 1'b0, newBusy = 1'b0, curIs32 = 1'b0, pagingOn = 1'b0;
  logic [255:0] curGpr = '0;
  logic [95:0] curSeg = '0;
  logic memReq, memWe, memWide, memAck = 1'b0;
  logic [31:0] memAddr, memWdata, memRdata = '0;
  logic done, setTs, clrOldBusy, setNewBusy, segLoad, cr3Load, newTrap, trIs32;
  logic [1:0] faultCode;
  logic [31:0] newIp, newFlags, newCr3, ioAddr, trBase, trLimit;
  logic [255:0] newGpr;
  logic [95:0] newSeg;
  logic [15:0] newLdt, ioLimit, trSel;

  int vectors = 0, miscompares = 0, accCount = 0;
  bit wrSeenTb = 0, rdAfterWr = 0;
  logic [7:0] mem [512];

  always #5 clk = ~clk;

  task_switch_seq u0 (.*);

  function automatic logic [15:0] rd16(input logic [31:0] a);
    return {mem[(a + 1) & 511], mem[a & 511]};
  endfunction
  function automatic logic [31:0] rd32(input logic [31:0] a);
    return {rd16(a + 2), rd16(a)};
  endfunction

  always @(negedge clk) begin
    if (memAck) memAck = 1'b0;
    else if (memReq) begin
      accCount++;
      if (memWe) begin
        wrSeenTb = 1;
        mem[memAddr & 511] = memWdata[7:0];
        mem[(memAddr + 1) & 511] = memWdata[15:8];
        if (memWide) begin
          mem[(memAddr + 2) & 511] = memWdata[23:16];
          mem[(memAddr + 3) & 511] = memWdata[31:24];
        end
      end else begin
        if (wrSeenTb) rdAfterWr = 1;
        memRdata = memWide ? rd32(memAddr) : {16'b0, rd16(memAddr)};
      end
      memAck = 1'b1;
    end
  end

  task automatic chk(input string req, input string what, input logic [255:0] got, input logic [255:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic doSwitch(input int kd, input bit n32, input bit o32, input bit pg,
                          input logic [31:0] lim, input int csMode, input bit busy,
                          input logic [15:0] iob, input int seed);
    logic [31:0] nb = 32'h100, cb = 32'h40;
    logic [31:0] eIp, eFlags, eCr3, eIoAddr, oldFlagsExp;
    logic [15:0] eLdt, eIoLim, oldLink, prevTr;
    logic [31:0] eGpr [8];
    logic [15:0] eSeg [6];
    bit eTrap, link, limOk, sTs, sSeg, sNew, sOld, sCr3;
    int eFault, expAcc;
    logic [1:0] gotFault;
    string ftag;
    for (int i = 0; i < 512; i++) mem[i] = 8'(i * 7 + seed * 13 + (i >> 3));
    if (n32) begin
      mem[nb + 102] = iob[7:0];
      mem[nb + 103] = iob[15:8];
    end
    kind = 2'(kd); newSel = 16'(16'h58 + seed); newBase = nb; newLimit = lim; newIs32 = n32;
    newBusy = busy; curSel = 16'(16'h30 + seed); curBase = cb; curIs32 = o32; pagingOn = pg;
    curIp = 32'h8000_1234 ^ 32'(seed); curFlags = 32'h0000_4206 ^ (32'(seed) << 16);
    for (int g = 0; g < 8; g++) curGpr[g*32 +: 32] = 32'hA000_0000 + 32'(seed * 256 + g * 17);
    for (int g = 0; g < 6; g++) curSeg[g*16 +: 16] = 16'(16'h0100 + seed * 8 + g);
    link = (kd == 1) || (kd == 2);
    eIp = n32 ? rd32(nb + 32) : {16'b0, rd16(nb + 14)};
    eFlags = (n32 ? rd32(nb + 36) : {16'b0, rd16(nb + 16)}) | (link ? 32'h4000 : 32'h0);
    for (int g = 0; g < 8; g++) eGpr[g] = n32 ? rd32(nb + 40 + 4*g) : {16'b0, rd16(nb + 18 + 2*g)};
    for (int g = 0; g < 6; g++)
      eSeg[g] = n32 ? rd16(nb + 72 + 4*g) : (g < 4 ? rd16(nb + 34 + 2*g) : 16'h0);
    eLdt = n32 ? rd16(nb + 96) : rd16(nb + 42);
    eTrap = n32 ? rd16(nb + 100) & 16'h1 : 1'b0;
    eCr3 = (n32 && pg) ? rd32(nb + 28) : 32'h0;
    if (n32 && iob != 0 && {16'b0, iob} < lim) begin
      eIoLim = 16'(lim - {16'b0, iob}); eIoAddr = nb + {16'b0, iob};
    end else begin
      eIoLim = 0; eIoAddr = 0;
    end
    csLimit = (csMode == 0) ? 32'hFFFF_FFFF : (csMode == 1) ? eIp - 1 : eIp;
    limOk = n32 ? (lim >= 32'h67) : (lim >= 32'h2B);
    eFault = !limOk ? 1 : (kd == 3 && !busy) ? 3 : (eIp > csLimit) ? 2 : 0;
    ftag = (eFault == 1) ? "R1" : (eFault == 3) ? "R7" : (eFault == 2) ? "R10" : "R8";
    oldLink = rd16(nb);
    prevTr = trSel;
    oldFlagsExp = curFlags & ((kd == 3) ? ~32'h4000 : 32'hFFFF_FFFF);
    accCount = 0; wrSeenTb = 0; rdAfterWr = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    while (!done) @(negedge clk);
    gotFault = faultCode; sTs = setTs; sSeg = segLoad; sNew = setNewBusy; sOld = clrOldBusy; sCr3 = cr3Load;
    chk(ftag, "faultCode", 256'(gotFault), 256'(eFault));
    if (eFault == 1 || eFault == 3) begin
      chk(ftag, "access count", 256'(accCount), 256'(0));
      chk(ftag, "strobes", {sTs, sSeg, sNew, sOld}, 256'(0));
      chk(ftag, "trSel kept", 256'(trSel), 256'(prevTr));
    end else begin
      expAcc = (n32 ? (pg ? 20 : 19) : 15) + (o32 ? 16 : 14) + (link ? 1 : 0);
      chk("R11", "access count", 256'(accCount), 256'(expAcc));
      chk("R4", "read after write", 256'(rdAfterWr), 256'(0));
      chk(n32 ? "R2" : "R3", "newIp", 256'(newIp), 256'(eIp));
      chk("R6", "newFlags", 256'(newFlags), 256'(eFlags));
      for (int g = 0; g < 8; g++) chk(n32 ? "R2" : "R3", "newGpr", 256'(newGpr[g*32 +: 32]), 256'(eGpr[g]));
      for (int g = 0; g < 6; g++) chk(n32 ? "R2" : "R3", "newSeg", 256'(newSeg[g*16 +: 16]), 256'(eSeg[g]));
      chk(n32 ? "R2" : "R3", "ldt/trap/cr3", {newLdt, newTrap, newCr3}, {eLdt, eTrap, eCr3});
      if (o32) begin
        chk("R5", "saved ip/flags", {rd32(cb + 32), rd32(cb + 36)}, {curIp, oldFlagsExp});
        for (int g = 0; g < 8; g++) chk("R5", "saved gpr", 256'(rd32(cb + 40 + 4*g)), 256'(curGpr[g*32 +: 32]));
        for (int g = 0; g < 6; g++) chk("R5", "saved seg", 256'(rd16(cb + 72 + 4*g)), 256'(curSeg[g*16 +: 16]));
      end else begin
        chk("R5", "saved ip/flags", {rd16(cb + 14), rd16(cb + 16)}, {curIp[15:0], oldFlagsExp[15:0]});
        for (int g = 0; g < 8; g++) chk("R5", "saved gpr", 256'(rd16(cb + 18 + 2*g)), 256'(curGpr[g*32 +: 16]));
        for (int g = 0; g < 4; g++) chk("R5", "saved seg", 256'(rd16(cb + 34 + 2*g)), 256'(curSeg[g*16 +: 16]));
      end
      chk("R6", "back link", 256'(rd16(nb)), 256'(link ? curSel : oldLink));
      chk("R7", "busy strobes", {sNew, sOld}, {kd != 3, kd == 0 || kd == 3});
      chk("R8", "ts/seg/cr3 strobes", {sTs, sSeg, sCr3}, {1'b1, 1'b1, n32 && pg});
      chk("R8", "task register", {trSel, trBase, trLimit, trIs32}, {newSel, nb, lim, n32});
      chk("R9", "io window", {ioLimit, ioAddr}, {eIoLim, eIoAddr});
    end
    @(negedge clk);
    chk("R8", "done pulse", 256'(done), 256'(0));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    int seed = 1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R11", "reset memReq/done", {memReq, done, setTs}, 256'(0));
    chk("R8", "reset task register", {trSel, trBase, trLimit, trIs32}, 256'(0));
    for (int kd = 0; kd < 4; kd++)
      for (int n = 0; n < 2; n++)
        for (int o = 0; o < 2; o++)
          for (int p = 0; p < 2; p++) begin
            doSwitch(kd, n[0], o[0], p[0], n[0] ? ((seed % 2) ? 32'h67 : 32'h200) : 32'h2B, 0, 1'b1,
                     (seed % 3 == 0) ? 16'h0 : (seed % 3 == 1) ? 16'h80 : 16'h300, seed);
            seed++;
          end
    doSwitch(0, 1, 1, 1, 32'h66, 0, 1'b1, 16'h40, 40);   // R1 one below 32-bit minimum
    doSwitch(1, 0, 0, 0, 32'h2A, 0, 1'b1, 16'h0, 41);    // R1 one below 16-bit minimum
    doSwitch(3, 1, 0, 0, 32'h200, 0, 1'b0, 16'h40, 42);  // R7 IRET into idle task
    doSwitch(0, 1, 1, 0, 32'h200, 0, 1'b0, 16'h40, 43);  // R7 busy ignored for JMP
    doSwitch(2, 1, 1, 1, 32'h200, 1, 1'b1, 16'h1FF, 44); // R10 ip one above limit
    doSwitch(1, 0, 1, 0, 32'h2B, 2, 1'b1, 16'h0, 45);    // R10 ip equal to limit
    doSwitch(0, 1, 0, 1, 32'h68, 0, 1'b1, 16'h67, 46);   // R9 window of length one
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule